// File: doc/BRIEF.md
# Effective Address Generation Unit

This block turns a decoded addressing-mode code and the values it depends on into the address of an operand. Each request gives the unit a mode code and a signed displacement or address field. It also gives the contents of the selected register, the program counter, the stack pointer and a base register. The unit answers with a one-cycle completion pulse. At that pulse it shows the resulting address and a flag that tells whether the operand is a register value rather than a memory location. Unknown mode codes are flagged instead of producing an address.

Most modes are pure arithmetic and finish on the cycle after the request. One mode treats the field as a pointer to a pointer. It reads memory once through a request/valid handshake and takes the returned word as the address. While that read is outstanding the unit is busy and ignores further requests. Instruction decode, the register file, stack-pointer maintenance and the memory are all outside the block.

Top module: `ea_gen`

## Requirements
- R1: Mode code 0 (direct): the field, zero-extended to the address width, becomes the address; `is_reg` and `illegal` are 0.
- R2: Mode code 1 (memory indirect): after `start`, `mem_req` rises on the next cycle with `mem_addr` holding the zero-extended field. Both are held until `mem_valid` is sampled high. On the cycle after that, `done` pulses, `ea` equals the `mem_rdata` sampled with `mem_valid`, and `mem_req` is 0.
- R3: Mode code 2 (register): `ea` carries `reg_val` and `is_reg` is 1; no memory read is issued.
- R4: Mode code 3 (register indirect): `reg_val` becomes the address; `is_reg` is 0.
- R5: Mode code 4 (stack): `sp` becomes the address.
- R6: Mode code 5 (relative): the address is `pc` plus the field sign-extended from its top bit, and any carry beyond the address width is dropped.
- R7: Mode code 6 (base): the address is `base_reg` plus the sign-extended field, with the carry dropped.
- R8: Mode code 7: `done` pulses with `illegal` at 1, `ea` at 0 and `is_reg` at 0; no memory read is issued.
- R9: For every mode except 1, `done` is high for exactly the cycle after the one in which `start` was sampled. A `start` presented during a `done` cycle is accepted.
- R10: A `start` sampled while a memory read is outstanding has no effect. This also holds in the same cycle as `mem_valid`. Only the pending read completes.
- R11: During and right after reset, `done`, `mem_req`, `mem_addr`, `ea`, `is_reg` and `illegal` are 0.
- R12: `mem_valid` arriving while no read is outstanding changes no output.
- R13: `ea`, `is_reg` and `illegal` keep their values between completions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a new address computation |
| mode | input | 3 | Addressing-mode code (0..7) |
| field | input | DISP_W | Address or signed displacement field |
| reg_val | input | ADDR_W | Contents of the selected register |
| pc | input | ADDR_W | Program counter |
| sp | input | ADDR_W | Stack pointer |
| base_reg | input | ADDR_W | Base register |
| mem_req | output | 1 | Memory read request, held until accepted |
| mem_addr | output | ADDR_W | Address of the pointer word to read |
| mem_valid | input | 1 | Read data is present on `mem_rdata` |
| mem_rdata | input | ADDR_W | Word returned by memory |
| done | output | 1 | One-cycle completion pulse |
| ea | output | ADDR_W | Resulting address (or register value in mode 2) |
| is_reg | output | 1 | Operand is the register value, not memory |
| illegal | output | 1 | Last request used an undefined mode code |

## Verification
Two events can collide. One is a new request arriving while the memory-indirect read is still pending. The worse case is that request landing exactly on the cycle the memory returns its word. The bench's memory model answers after a chosen latency, so a request can be timed to land on that very cycle, and others can be timed to land earlier in the wait. A behavioural reference model tracks busy and idle on every clock and must show only the pointer word becoming the address, with no second completion. A stray `mem_valid` while idle is also provoked and must leave every output untouched.

// File: rtl/ea_pkg.sv
package ea_pkg;

    typedef enum logic [2:0] {
        AM_DIRECT   = 3'd0,
        AM_INDIRECT = 3'd1,
        AM_REG      = 3'd2,
        AM_REGIND   = 3'd3,
        AM_STACK    = 3'd4,
        AM_REL      = 3'd5,
        AM_BASE     = 3'd6,
        AM_BAD      = 3'd7
    } am_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_FETCH = 1'b1
    } st_e;

endpackage

// File: rtl/ea_arith.sv
module ea_arith
    import ea_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DISP_W = 12
) (
    input  am_e               mode,
    input  logic [DISP_W-1:0] field,
    input  logic [ADDR_W-1:0] reg_val,
    input  logic [ADDR_W-1:0] pc,
    input  logic [ADDR_W-1:0] sp,
    input  logic [ADDR_W-1:0] base_reg,
    output logic [ADDR_W-1:0] addr,
    output logic              is_reg,
    output logic              illegal,
    output logic              need_mem
);

    localparam int EXT_W = ADDR_W - DISP_W;

    logic [ADDR_W-1:0] field_sx;
    logic [ADDR_W-1:0] field_zx;
    logic [ADDR_W-1:0] rel_sum;
    logic [ADDR_W-1:0] base_sum;

    generate
        if (DISP_W < ADDR_W) begin : g_widen
            assign field_sx = {{EXT_W{field[DISP_W-1]}}, field};
            assign field_zx = {{EXT_W{1'b0}}, field};
        end else begin : g_narrow
            assign field_sx = field[ADDR_W-1:0];
            assign field_zx = field[ADDR_W-1:0];
        end
    endgenerate

    // Carry beyond ADDR_W is discarded by the result width.
    assign rel_sum  = pc + field_sx;
    assign base_sum = base_reg + field_sx;

    always_comb begin
        addr     = '0;
        is_reg   = 1'b0;
        illegal  = 1'b0;
        need_mem = 1'b0;
        unique case (mode)
            AM_DIRECT:   addr = field_zx;
            AM_INDIRECT: begin
                addr     = field_zx;
                need_mem = 1'b1;
            end
            AM_REG: begin
                addr   = reg_val;
                is_reg = 1'b1;
            end
            AM_REGIND:   addr = reg_val;
            AM_STACK:    addr = sp;
            AM_REL:      addr = rel_sum;
            AM_BASE:     addr = base_sum;
            default:     illegal = 1'b1;
        endcase
    end

endmodule

// File: rtl/ea_ctrl.sv
module ea_ctrl
    import ea_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] calc_addr,
    input  logic              calc_is_reg,
    input  logic              calc_illegal,
    input  logic              calc_need_mem,
    input  logic              mem_valid,
    input  logic [ADDR_W-1:0] mem_rdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              done,
    output logic [ADDR_W-1:0] ea,
    output logic              is_reg,
    output logic              illegal
);

    typedef struct packed {
        st_e               st;
        logic              req;
        logic [ADDR_W-1:0] maddr;
        logic              done;
        logic [ADDR_W-1:0] ea;
        logic              is_reg;
        logic              ill;
    } regs_t;

    localparam regs_t RESET_V = '{st: ST_IDLE, req: 1'b0, maddr: '0,
                                  done: 1'b0, ea: '0, is_reg: 1'b0, ill: 1'b0};

    regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    if (calc_need_mem) begin
                        r_d.st    = ST_FETCH;
                        r_d.req   = 1'b1;
                        r_d.maddr = calc_addr;
                    end else begin
                        r_d.done   = 1'b1;
                        r_d.ea     = calc_addr;
                        r_d.is_reg = calc_is_reg;
                        r_d.ill    = calc_illegal;
                    end
                end
            end
            ST_FETCH: begin
                if (mem_valid) begin
                    r_d.st     = ST_IDLE;
                    r_d.req    = 1'b0;
                    r_d.done   = 1'b1;
                    r_d.ea     = mem_rdata;
                    r_d.is_reg = 1'b0;
                    r_d.ill    = 1'b0;
                end
            end
            default: r_d = RESET_V;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= RESET_V;
        else        r_q <= r_d;
    end

    assign mem_req  = r_q.req;
    assign mem_addr = r_q.maddr;
    assign done     = r_q.done;
    assign ea       = r_q.ea;
    assign is_reg   = r_q.is_reg;
    assign illegal  = r_q.ill;

    // R2: request held, address stable, until accepted
    a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_valid |=> mem_req && $stable(mem_addr));
    // R2: completion follows acceptance by one cycle
    a_r2_done_after_valid: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_valid |=> done && !mem_req && ea == $past(mem_rdata));
    // R10: no completion while a read is pending
    a_r10_no_done_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !done);
    // R9: arithmetic modes finish on the next cycle
    a_r9_done_next: assert property (@(posedge clk) disable iff (!rst_n)
        start && !mem_req && !calc_need_mem |=> done);
    // R8: illegal flag only appears with a completion
    a_r8_ill_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(illegal) |-> done);
    // R13: results hold between completions
    a_r13_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(ea) && $stable(is_reg) && $stable(illegal));

endmodule

// File: rtl/ea_gen.sv
module ea_gen
    import ea_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DISP_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        mode,
    input  logic [DISP_W-1:0] field,
    input  logic [ADDR_W-1:0] reg_val,
    input  logic [ADDR_W-1:0] pc,
    input  logic [ADDR_W-1:0] sp,
    input  logic [ADDR_W-1:0] base_reg,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_valid,
    input  logic [ADDR_W-1:0] mem_rdata,
    output logic              done,
    output logic [ADDR_W-1:0] ea,
    output logic              is_reg,
    output logic              illegal
);

    logic [ADDR_W-1:0] calc_addr;
    logic              calc_is_reg;
    logic              calc_illegal;
    logic              calc_need_mem;

    ea_arith #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_arith (
        .mode     (am_e'(mode)),
        .field    (field),
        .reg_val  (reg_val),
        .pc       (pc),
        .sp       (sp),
        .base_reg (base_reg),
        .addr     (calc_addr),
        .is_reg   (calc_is_reg),
        .illegal  (calc_illegal),
        .need_mem (calc_need_mem)
    );

    ea_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .calc_addr     (calc_addr),
        .calc_is_reg   (calc_is_reg),
        .calc_illegal  (calc_illegal),
        .calc_need_mem (calc_need_mem),
        .mem_valid     (mem_valid),
        .mem_rdata     (mem_rdata),
        .mem_req       (mem_req),
        .mem_addr      (mem_addr),
        .done          (done),
        .ea            (ea),
        .is_reg        (is_reg),
        .illegal       (illegal)
    );

    // R3/R8: register and illegal results never coincide
    a_r3_reg_not_ill: assert property (@(posedge clk) disable iff (!rst_n)
        done && is_reg |-> !illegal && !mem_req);

endmodule

// File: tb/sim_ea_gen.sv
module sim_ea_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  mode = 3'd0;
    logic [11:0] field = '0;
    logic [15:0] reg_val = '0, pc = '0, sp = '0, base_reg = '0;
    logic        mem_valid = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic        mem_req, done, is_reg, illegal;
    logic [15:0] mem_addr, ea;

    int checks = 0;
    int errors = 0;
    bit run_chk = 1'b0;

    always #2 clk = ~clk;

    ea_gen u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .field(field),
        .reg_val(reg_val), .pc(pc), .sp(sp), .base_reg(base_reg),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid),
        .mem_rdata(mem_rdata), .done(done), .ea(ea), .is_reg(is_reg),
        .illegal(illegal)
    );

    // behavioural memory: answers after lat waiting cycles
    int lat = 0;
    int wcnt = 0;
    bit stray = 1'b0;

    function automatic logic [15:0] mem_word(input logic [15:0] a);
        return a * 16'd7 + 16'h0103;
    endfunction

    always @(negedge clk) begin
        if (mem_valid) begin
            mem_valid = 1'b0;
            wcnt = 0;
        end else if (stray) begin
            mem_valid = 1'b1;
            mem_rdata = 16'hDEAD;
            stray = 1'b0;
        end else if (mem_req) begin
            if (wcnt >= lat) begin
                mem_valid = 1'b1;
                mem_rdata = mem_word(mem_addr);
            end else begin
                wcnt++;
            end
        end
    end

    // reference model
    bit          m_busy = 0, m_done = 0, m_req = 0, m_isreg = 0, m_ill = 0;
    logic [15:0] m_addr = '0, m_ea = '0;
    string       tag = "R11";

    function automatic string mode_tag(input logic [2:0] m);
        case (m)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R4";
            3'd4: return "R5";
            3'd5: return "R6";
            3'd6: return "R7";
            default: return "R8";
        endcase
    endfunction

    function automatic logic [15:0] widen_signed(input logic [11:0] f);
        int v;
        v = int'(f);
        if (v >= 2048) v = v - 4096;
        return 16'(v);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_req = 0; m_isreg = 0; m_ill = 0;
            m_addr = '0; m_ea = '0;
        end else if (!m_busy) begin
            m_done = 0;
            if (mem_valid) tag = "R12";
            if (start) begin
                tag = mode_tag(mode);
                if (start && mode == 3'd1) begin
                    m_busy = 1; m_req = 1; m_addr = {4'h0, field};
                end else begin
                    m_done = 1; m_isreg = 0; m_ill = 0;
                    case (mode)
                        3'd0: m_ea = {4'h0, field};
                        3'd2: begin m_ea = reg_val; m_isreg = 1; end
                        3'd3: m_ea = reg_val;
                        3'd4: m_ea = sp;
                        3'd5: m_ea = pc + widen_signed(field);
                        3'd6: m_ea = base_reg + widen_signed(field);
                        default: begin m_ea = '0; m_ill = 1; end
                    endcase
                end
            end
        end else begin
            m_done = 0;
            if (start) tag = "R10";
            if (mem_valid) begin
                m_busy = 0; m_req = 0; m_done = 1;
                m_ea = mem_rdata; m_isreg = 0; m_ill = 0;
            end
        end
    end

    // compare every cycle, away from the active edge (R13 covered by holds)
    always @(negedge clk) begin
        if (run_chk) begin
            checks++;
            if (done !== m_done || mem_req !== m_req || mem_addr !== m_addr ||
                ea !== m_ea || is_reg !== m_isreg || illegal !== m_ill) begin
                errors++;
                $display("FAIL %s: act done=%b req=%b maddr=%h ea=%h reg=%b ill=%b exp done=%b req=%b maddr=%h ea=%h reg=%b ill=%b",
                         tag, done, mem_req, mem_addr, ea, is_reg, illegal,
                         m_done, m_req, m_addr, m_ea, m_isreg, m_ill);
            end
        end
    end

    task automatic issue(input logic [2:0] m, input logic [11:0] f);
        @(negedge clk);
        mode = m; field = f; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 40 && !done; i++) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: act hung exp finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R11: reset state
        repeat (2) @(negedge clk);
        checks++;
        if (done !== 0 || mem_req !== 0 || mem_addr !== 0 || ea !== 0 || is_reg !== 0 || illegal !== 0) begin
            errors++;
            $display("FAIL R11: act done=%b req=%b ea=%h exp all zero", done, mem_req, ea);
        end
        rst_n = 1'b1;
        run_chk = 1'b1;
        @(negedge clk);

        reg_val = 16'hBEEF; pc = 16'h0002; sp = 16'h7FFE; base_reg = 16'hFFFF;
        issue(3'd0, 12'h123);          // R1
        issue(3'd0, 12'hFFF);          // R1 zero extension
        issue(3'd2, 12'h000);          // R3
        reg_val = 16'h4000;
        issue(3'd3, 12'h055);          // R4
        issue(3'd4, 12'h000);          // R5
        issue(3'd5, 12'hFFB);          // R6 negative, wraps to FFFD
        pc = 16'h1000;
        issue(3'd5, 12'h7FF);          // R6 positive
        issue(3'd6, 12'h001);          // R7 carry dropped
        base_reg = 16'h2000;
        issue(3'd6, 12'h800);          // R7 most negative
        issue(3'd7, 12'h0AA);          // R8
        lat = 0; issue(3'd1, 12'h010); // R2
        lat = 3; issue(3'd1, 12'h234); // R2
        lat = 1; issue(3'd1, 12'hFFE); // R2

        // R10: start early in the wait
        lat = 3;
        @(negedge clk); mode = 3'd1; field = 12'h300; start = 1'b1;
        @(negedge clk); start = 1'b0;
        @(negedge clk); mode = 3'd0; field = 12'h777; start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (5) @(negedge clk);

        // R10: start in the very cycle mem_valid arrives
        lat = 2;
        @(negedge clk); mode = 3'd1; field = 12'h404; start = 1'b1;
        @(negedge clk); start = 1'b0;
        @(negedge clk);
        @(negedge clk); mode = 3'd4; start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (3) @(negedge clk);

        // R12: stray valid while idle
        stray = 1'b1;
        repeat (4) @(negedge clk);

        // R9: back-to-back, second start during the done cycle
        @(negedge clk); mode = 3'd0; field = 12'h0F0; start = 1'b1;
        @(negedge clk); mode = 3'd7;
        @(negedge clk); mode = 3'd3; start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (3) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule